// File: doc/BRIEF.md
# Two-Chip Lookup Cascade Controller

This controller sits beside the search engine of an associative lookup device. Two such devices can share one host bus and one read-data bus, and each device carries one copy of the controller. A strap input sets the copy's role. The master owns connection indices 0 to 8191 and the slave owns 8192 to 16383, so bit 13 of the 14-bit index selects the owner. Each copy sends a 3-bit cascade word to its partner and receives the partner's word. The low two bits report the state of the local request. The third bit is a data-bus grant, which only the master drives.

Requests enter through a valid/ready handshake. `req_ready` is high only while no request is in flight, and a request is taken on a clock where `req_valid` and `req_ready` are both high. While a request is in flight, the requester must hold `req_valid` and its fields until `req_ready` returns. That happens on the clock after `req_done` ends the request.

Once a request is taken, the controller keeps three things up to date. It combines the local and remote search results. It decides which chip may drive read data. For index-addressed reads and writes, it raises `respond` only on the chip that owns the index. A single chip works on its own when strapped as master with `casc_in` tied to 000: the missing partner then always reads as a mismatch.

Top module: `casc_ctrl`

## Requirements
- R1: A synchronous reset sets `casc_out` to 3'b010 and sets `rd_oe` and `respond` to 0. `req_ready` is 1 after reset.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1, and `req_ready` is 0 from the next clock on. While the controller is busy, `req_valid` has no effect. The clock after `req_done` arrives during a busy period, `req_ready` is 1 and `casc_out[1:0]` is 10.
- R3: The request type is a 3-bit code: 0 is an indexed write, 1 to 3 are searches, 4 is a search only when `cee` is 1, and 7 is an indexed read. From the clock after acceptance, `casc_out[1:0]` is 11 for every type that is not a search. For a search it is 00 when the local result is a mismatch and 01 when it is a match, following `local_hit` with one clock of delay. The code is 10 only when the controller is idle.
- R4: `role` = 0 selects master, which owns every index with bit 13 = 0. `role` = 1 selects slave, which owns every index with bit 13 = 1. Both 8191 (0x1FFF) and 0 belong to the master; both 8192 and 16383 belong to the slave.
- R5: During an indexed read or write, a master sets `casc_out[2]` to bit 13 of the accepted index, starting on the clock after acceptance.
- R6: During a search, a master registers `casc_out[2]` = 1 exactly when its own `local_hit` is 0 and `casc_in[1:0]` is 01 in that same cycle. Otherwise it registers 0.
- R7: A slave always drives `casc_out[2]` = 0. A master's `rd_oe` does not depend on `casc_in[2]`.
- R8: A master's `rd_oe` is 1 during an indexed read of an index it owns. It is also 1 during a search while its own `casc_out[2]` is 0. In every other case it is 0, so a master with its grant bit set never drives.
- R9: A slave's `rd_oe` is 1 only while `casc_in[2]` is 1 and the slave either holds an indexed read of an index it owns or reports search code 01.
- R10: `respond` is 1 only while an indexed read or write is busy on the chip that owns its index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| role | input | 1 | Strap: 0 master, 1 slave |
| cee | input | 1 | Mode bit that makes type 4 a search |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_type | input | 3 | Request type code |
| req_idx | input | 14 | Connection index of read/write |
| req_done | input | 1 | Ends the busy request |
| local_hit | input | 1 | Local search result: 1 match, 0 mismatch |
| casc_in | input | 3 | Partner's cascade word |
| casc_out | output | 3 | Local cascade word {grant, status} |
| rd_oe | output | 1 | Local read-data bus enable |
| respond | output | 1 | This chip answers the read/write |

## Verification
The assertions assume that `role` changes only while `rst` is high. They also assume that `req_done` is pulsed only while `req_ready` is 0, and that `casc_in` comes from a partner that uses the same status codes. The stimulus keeps to these assumptions: it changes the strap only inside a reset window, raises `req_done` only during busy periods, and drives `casc_in` only with values a well-behaved partner could send. Master and slave behaviour are exercised in two separate runs of one instance, each started from reset.

// File: rtl/casc_pkg.sv
package casc_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [1:0] {
    CL_SEARCH = 2'd0,
    CL_OTHER  = 2'd1,
    CL_READ   = 2'd2,
    CL_WRITE  = 2'd3
  } req_class_e;

  localparam logic [1:0] ST_MISS = 2'b00;
  localparam logic [1:0] ST_HIT  = 2'b01;
  localparam logic [1:0] ST_IDLE = 2'b10;
  localparam logic [1:0] ST_BUSY = 2'b11;

  function automatic req_class_e classify(input logic [TYPE_W-1:0] t, input logic cee);
    case (t)
      3'd0:             return CL_WRITE;
      3'd1, 3'd2, 3'd3: return CL_SEARCH;
      3'd4:             return cee ? CL_SEARCH : CL_OTHER;
      3'd7:             return CL_READ;
      default:          return CL_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/casc_req_tracker.sv
module casc_req_tracker
  import casc_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  req_class_e       cls_new,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_done,
  output logic             accept_o,
  output logic             busy_o,
  output req_class_e       cls_o,
  output logic             hi_o
);
  localparam int OWN_BIT = IDX_W - 1;

  // a request in flight blocks new ones (R2)
  assign accept_o = req_valid && !busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cls_o  <= CL_OTHER;
      hi_o   <= 1'b0;
    end else if (busy_o && req_done) begin
      busy_o <= 1'b0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      cls_o  <= cls_new;
      hi_o   <= req_idx[OWN_BIT];
    end
  end
endmodule

// File: rtl/casc_status_gen.sv
module casc_status_gen
  import casc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       role,
  input  logic       accept_i,
  input  req_class_e cls_new,
  input  logic       hi_new,
  input  logic       busy_i,
  input  req_class_e cls_q,
  input  logic       done_i,
  input  logic       local_hit,
  input  logic [1:0] peer_code,
  output logic [1:0] code_o,
  output logic       grant_o
);
  logic search_grant;
  logic rw_new;

  // master hands the bus over only on local miss plus remote hit (R6)
  assign search_grant = !role && !local_hit && (peer_code == ST_HIT);
  assign rw_new       = (cls_new == CL_READ) || (cls_new == CL_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= ST_IDLE;
      grant_o <= 1'b0;
    end else if (busy_i && done_i) begin
      code_o  <= ST_IDLE;
      grant_o <= 1'b0;
    end else if (accept_i) begin
      if (cls_new == CL_SEARCH) begin
        code_o  <= {1'b0, local_hit};
        grant_o <= search_grant;
      end else begin
        code_o  <= ST_BUSY;
        grant_o <= !role && rw_new && hi_new;   // R5
      end
    end else if (busy_i && cls_q == CL_SEARCH) begin
      code_o  <= {1'b0, local_hit};
      grant_o <= search_grant;
    end
  end
endmodule

// File: rtl/casc_bus_arbiter.sv
module casc_bus_arbiter
  import casc_pkg::*;
(
  input  logic       role,
  input  logic       busy_i,
  input  req_class_e cls_q,
  input  logic       hi_q,
  input  logic       grant_q,
  input  logic [1:0] code_q,
  input  logic       peer_grant,
  output logic       rd_oe,
  output logic       respond
);
  logic own_idx;
  logic master_owns;
  logic slave_owns;

  // index ownership follows the role strap (R4)
  assign own_idx = (hi_q == role);

  // R8
  assign master_owns = ((cls_q == CL_READ) && own_idx) ||
                       ((cls_q == CL_SEARCH) && !grant_q);
  // R9
  assign slave_owns  = ((cls_q == CL_READ) && own_idx) ||
                       ((cls_q == CL_SEARCH) && (code_q == ST_HIT));

  assign rd_oe = busy_i && (role ? (peer_grant && slave_owns) : master_owns);

  // R10
  assign respond = busy_i && ((cls_q == CL_READ) || (cls_q == CL_WRITE)) && own_idx;
endmodule

// File: rtl/casc_ctrl.sv
module casc_ctrl
  import casc_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             role,
  input  logic             cee,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_type,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_done,
  input  logic             local_hit,
  input  logic [2:0]       casc_in,
  output logic [2:0]       casc_out,
  output logic             rd_oe,
  output logic             respond
);
  localparam int OWN_BIT = IDX_W - 1;

  req_class_e cls_new;
  req_class_e cls_q;
  logic       accept;
  logic       busy;
  logic       hi_q;
  logic [1:0] code_q;
  logic       grant_q;

  assign cls_new = classify(req_type, cee);

  casc_req_tracker #(.IDX_W(IDX_W)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .cls_new   (cls_new),
    .req_idx   (req_idx),
    .req_done  (req_done),
    .accept_o  (accept),
    .busy_o    (busy),
    .cls_o     (cls_q),
    .hi_o      (hi_q)
  );

  casc_status_gen u_stat (
    .clk       (clk),
    .rst       (rst),
    .role      (role),
    .accept_i  (accept),
    .cls_new   (cls_new),
    .hi_new    (req_idx[OWN_BIT]),
    .busy_i    (busy),
    .cls_q     (cls_q),
    .done_i    (req_done),
    .local_hit (local_hit),
    .peer_code (casc_in[1:0]),
    .code_o    (code_q),
    .grant_o   (grant_q)
  );

  // R7: only the slave path looks at casc_in[2]
  casc_bus_arbiter u_arb (
    .role       (role),
    .busy_i     (busy),
    .cls_q      (cls_q),
    .hi_q       (hi_q),
    .grant_q    (grant_q),
    .code_q     (code_q),
    .peer_grant (casc_in[2]),
    .rd_oe      (rd_oe),
    .respond    (respond)
  );

  assign req_ready = !busy;
  assign casc_out  = {grant_q, code_q};
endmodule

// File: rtl/casc_ctrl_chk.sv
module casc_ctrl_chk #(
  parameter int IDX_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             role,
  input logic             cee,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_type,
  input logic [IDX_W-1:0] req_idx,
  input logic             req_done,
  input logic             local_hit,
  input logic [2:0]       casc_in,
  input logic [2:0]       casc_out,
  input logic             rd_oe,
  input logic             respond
);
  // R2
  accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  done_idles_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && req_done) |=> (req_ready && casc_out[1:0] == 2'b10));

  // R3
  busy_code_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (casc_out[1:0] != 2'b10));

  // R7
  slave_grant_low_chk: assert property (@(posedge clk) disable iff (rst)
    role |-> !casc_out[2]);

  // R8
  master_yields_chk: assert property (@(posedge clk) disable iff (rst)
    (!role && casc_out[2]) |-> !rd_oe);

  // R9
  slave_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (role && !casc_in[2]) |-> !rd_oe);

  // R10
  respond_busy_chk: assert property (@(posedge clk) disable iff (rst)
    respond |-> !req_ready);
endmodule

bind casc_ctrl casc_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/casc_ctrl_bench.sv
module casc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        role = 1'b0;
  logic        cee = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_type = 3'd0;
  logic [13:0] req_idx = 14'd0;
  logic        req_done = 1'b0;
  logic        local_hit = 1'b0;
  logic [2:0]  casc_in = 3'b000;
  logic [2:0]  casc_out;
  logic        rd_oe;
  logic        respond;

  typedef struct {
    logic [2:0] out;
    logic       oe;
    logic       rsp;
    logic       rdy;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  casc_ctrl u_casc_ctrl (
    .clk, .rst, .role, .cee, .req_valid, .req_ready, .req_type, .req_idx,
    .req_done, .local_hit, .casc_in, .casc_out, .rd_oe, .respond
  );

  // monitor: compare mid-cycle, away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (casc_out !== e.out || rd_oe !== e.oe || respond !== e.rsp || req_ready !== e.rdy) begin
        n_bad++;
        $display("FAIL %s actual out=%b oe=%b rsp=%b rdy=%b expected out=%b oe=%b rsp=%b rdy=%b",
                 e.tag, casc_out, rd_oe, respond, req_ready, e.out, e.oe, e.rsp, e.rdy);
      end
    end
  end

  // driver: set this cycle's inputs, queue outputs expected during this cycle
  task automatic step(input logic v, input logic [2:0] t, input logic [13:0] idx,
                      input logic hit, input logic dn, input logic [2:0] cin,
                      input logic [2:0] eo, input logic eoe, input logic ersp,
                      input logic erdy, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    req_valid = v; req_type = t; req_idx = idx;
    local_hit = hit; req_done = dn; casc_in = cin;
    e.out = eo; e.oe = eoe; e.rsp = ersp; e.rdy = erdy; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_reset(input logic r);
    @(posedge clk);
    #1;
    rst = 1'b1; role = r; req_valid = 1'b0; req_done = 1'b0; casc_in = 3'b000;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    // ---- master, single-chip tie-off ----
    do_reset(1'b0);
    step(0, 0, 0, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R1 reset state");
    step(1, 1, 0, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 idle accepts search");
    step(0, 0, 0, 0, 0, 3'b000, 3'b000, 1, 0, 0, "R3 search miss code");
    step(0, 0, 0, 1, 0, 3'b001, 3'b000, 1, 0, 0, "R8 master keeps bus on miss");
    step(0, 0, 0, 0, 0, 3'b001, 3'b001, 1, 0, 0, "R6 local hit keeps grant low");
    step(0, 0, 0, 0, 1, 3'b001, 3'b100, 0, 0, 0, "R6 miss plus peer hit grants");
    step(1, 7, 14'h2000, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 done returns idle");
    step(1, 5, 0, 0, 0, 3'b000, 3'b111, 0, 0, 0, "R5 read of slave index grants");
    step(0, 0, 0, 0, 1, 3'b000, 3'b111, 0, 0, 0, "R2 valid ignored while busy");
    step(1, 0, 14'h0005, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 idle before write");
    step(0, 0, 0, 0, 0, 3'b000, 3'b011, 0, 1, 0, "R10 master answers own write");
    step(0, 0, 0, 0, 1, 3'b000, 3'b011, 0, 1, 0, "R3 write code 11");
    step(1, 7, 14'h1FFF, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 idle before read 8191");
    step(0, 0, 0, 0, 1, 3'b000, 3'b011, 1, 1, 0, "R4 index 8191 owned by master");
    cee = 1'b0;
    step(1, 4, 0, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 idle before type 4");
    step(0, 0, 0, 0, 1, 3'b000, 3'b011, 0, 0, 0, "R3 type 4 without cee is 11");
    cee = 1'b1;
    step(1, 4, 0, 1, 0, 3'b100, 3'b010, 0, 0, 1, "R2 idle before type 4 cee");
    step(0, 0, 0, 1, 1, 3'b100, 3'b001, 1, 0, 0, "R7 master ignores casc_in[2]");
    step(0, 0, 0, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 idle after cee search");
    cee = 1'b0;

    // ---- slave ----
    do_reset(1'b1);
    step(0, 0, 0, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R1 slave reset state");
    step(1, 2, 0, 1, 0, 3'b000, 3'b010, 0, 0, 1, "R2 slave accepts search");
    step(0, 0, 0, 1, 0, 3'b000, 3'b001, 0, 0, 0, "R9 slave hit without permission");
    step(0, 0, 0, 1, 0, 3'b100, 3'b001, 1, 0, 0, "R9 slave hit with permission");
    step(0, 0, 0, 1, 1, 3'b100, 3'b001, 1, 0, 0, "R7 slave grant bit stays 0");
    step(1, 7, 14'h3FFF, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 slave idle before read");
    step(0, 0, 0, 0, 0, 3'b000, 3'b011, 0, 1, 0, "R10 slave answers index 16383");
    step(0, 0, 0, 0, 1, 3'b100, 3'b011, 1, 1, 0, "R9 slave drives permitted read");
    step(1, 7, 14'h0000, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 slave idle before read 0");
    step(0, 0, 0, 0, 1, 3'b100, 3'b011, 0, 0, 0, "R4 index 0 not owned by slave");
    step(0, 0, 0, 0, 0, 3'b000, 3'b010, 0, 0, 1, "R2 slave idle at end");

    @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule